// File: doc/BRIEF.md
# Superframe Maintenance Channel Controller

This block follows the position of the line framer inside an eight-frame superframe and moves maintenance data between a host register port and the framer at fixed frame boundaries. Each basic frame carries 120 quats. The framer pulses a quat strobe once per quat and flags the first quat of a superframe with a start marker. From these two inputs the block keeps a quat index and a frame index, and it decodes the last quat of frame 4 (the mid point) and the last quat of frame 8 (the superframe end).

There are three maintenance subchannels: M4, M5/M6 and eoc. Each has a receive register, a host-written transmit holding register and an active transmit register that the framer sends. The receive register captures the framer's assembled data at the subchannel's boundary, and the holding register is copied to the active register at the same boundary. Every capture sets a per-channel status bit. A host read of the matching receive register clears that bit. The enabled status bits are ORed into one interrupt line. A control register drives a corrupt-CRC output for the framer. In one-shot mode that output clears itself when the superframe ends.

Top module: `mch_sframe_ctrl`

## Requirements
- R1: After reset the position is quat index 119 of frame index 7, so the first strobe reads quat 0 of frame 0. Each strobe advances the quat index from 0 to 119 and then the frame index from 0 to 7, with wrap. A strobe that carries the start marker moves the position to quat 0 of frame 0. The start marker has no effect without a strobe.
- R2: The strobe that brings the position to quat 119 of frame 3 (the mid point) loads the M5/M6 receive register from its framer input.
- R3: The strobe that brings the position to quat 119 of frame 7 (the superframe end) loads the M4 receive register from its framer input.
- R4: The eoc receive register loads from its framer input at both the mid point and the superframe end.
- R5: A host write with select 0 (M4), 1 (M5/M6) or 2 (eoc) updates only the holding register. The active transmit output changes only when the holding value is copied at that channel's own load points (R2 to R4). A write in the cycle of a copy reaches the output at the following copy point.
- R6: Status bit 0 (M4) sets at the superframe end, bit 1 (M5/M6) sets at the mid point, and bit 2 (eoc) sets at both points. A read with select 4 returns the status bits in bits 2:0.
- R7: A host read strobe with select 0, 1 or 2 returns that receive register and clears the matching status bit. If the bit is set again in the same cycle, the set wins. A value presented on the read select without the read strobe clears nothing.
- R8: The interrupt output is high exactly when some status bit and its enable bit are both 1. The enables are control bits 4:2, ordered like the status bits.
- R9: The control register has select 3: bit 0 is corrupt-CRC and bit 1 is one-shot mode, and it reads back in bits 4:0. When one-shot is 1, corrupt-CRC clears itself at the next superframe end unless a control write happens in that same cycle, in which case the write wins.
- R10: When one-shot is 0, corrupt-CRC keeps its value across superframe ends until the host writes the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| quat_stb | input | 1 | One pulse per received quat |
| sf_start | input | 1 | Marks the strobed quat as quat 0 of frame 0 |
| rx_m4_in | input | DW | M4 data assembled by the framer |
| rx_m56_in | input | DW | M5/M6 data assembled by the framer |
| rx_eoc_in | input | DW | eoc data assembled by the framer |
| host_wr | input | 1 | Host write strobe |
| host_wsel | input | 3 | Write select: 0..2 holding registers, 3 control |
| host_wdata | input | DW | Host write data |
| host_rd | input | 1 | Host read strobe (clears status on selects 0..2) |
| host_rsel | input | 3 | Read select: 0..2 receive, 3 control, 4 status |
| host_rdata | output | DW | Read data for host_rsel, same cycle |
| tx_m4_out | output | DW | Active M4 transmit value |
| tx_m56_out | output | DW | Active M5/M6 transmit value |
| tx_eoc_out | output | DW | Active eoc transmit value |
| crc_bad | output | 1 | Framer sends a corrupt CRC while high |
| irq | output | 1 | Combined enabled status |
| quat_idx | output | 7 | Index of the last strobed quat, 0..119 |
| frame_idx | output | 3 | Index of the current basic frame, 0..7 |

## Verification
The assertions assume that the framer inputs are valid in the cycle of the strobe that ends a frame, and that the start marker only comes together with a strobe. They also assume that the host touches each register at most once per cycle. The bench holds all inputs steady from one falling edge to the next. It drives random strobe gaps with random data, and it asserts the start marker only at a superframe boundary or in a deliberate resync. Host traffic lands on random cycles. Directed cases put host writes and reads on the exact boundary cycles.

// File: rtl/mch_pkg.sv
package mch_pkg;
  localparam int NCH    = 3;
  localparam int CH_M4  = 0;
  localparam int CH_M56 = 1;
  localparam int CH_EOC = 2;

  typedef enum logic [2:0] {
    SEL_M4   = 3'd0,
    SEL_M56  = 3'd1,
    SEL_EOC  = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_STAT = 3'd4
  } sel_e;

  localparam int CTRL_CORRUPT = 0;
  localparam int CTRL_ONESHOT = 1;
  localparam int CTRL_EN_LSB  = 2;
  localparam int CTRL_BITS    = CTRL_EN_LSB + NCH;
endpackage

// File: rtl/mch_sf_pos.sv
module mch_sf_pos #(
  parameter int QPF = 120,
  parameter int FPS = 8,
  parameter int QW  = 7,
  parameter int FW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          quat_stb,
  input  logic          sf_start,
  output logic [QW-1:0] quat_idx,
  output logic [FW-1:0] frame_idx,
  output logic          ev_mid,
  output logic          ev_sf_end
);
  localparam logic [QW-1:0] Q_LAST = QW'(QPF - 1);
  localparam logic [FW-1:0] F_LAST = FW'(FPS - 1);
  localparam logic [FW-1:0] F_MID  = FW'(FPS / 2 - 1);

  function automatic logic [QW-1:0] next_quat(input logic [QW-1:0] q, input logic sync);
    if (sync || q == Q_LAST) return '0;
    return q + QW'(1);
  endfunction

  function automatic logic [FW-1:0] next_frame(input logic [QW-1:0] q, input logic [FW-1:0] f,
                                               input logic sync);
    if (sync) return '0;
    if (q != Q_LAST) return f;
    if (f == F_LAST) return '0;
    return f + FW'(1);
  endfunction

  logic [QW-1:0] nq;
  logic [FW-1:0] nf;
  logic          ev_frame_end;

  always_comb begin
    nq = next_quat(quat_idx, sf_start);
    nf = next_frame(quat_idx, frame_idx, sf_start);
  end

  assign ev_frame_end = quat_stb && (nq == Q_LAST);
  assign ev_mid       = ev_frame_end && (nf == F_MID);
  assign ev_sf_end    = ev_frame_end && (nf == F_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quat_idx  <= Q_LAST;
      frame_idx <= F_LAST;
    end else if (quat_stb) begin
      quat_idx  <= nq;
      frame_idx <= nf;
    end
  end
endmodule

// File: rtl/mch_chan_buf.sv
module mch_chan_buf #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] rx_in,
  input  logic          hold_wr,
  input  logic [DW-1:0] hold_d,
  output logic [DW-1:0] rx_q,
  output logic [DW-1:0] hold_q,
  output logic [DW-1:0] tx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      hold_q <= '0;
      tx_q   <= '0;
    end else begin
      if (load) begin
        rx_q <= rx_in;
        tx_q <= hold_q;
      end
      if (hold_wr) hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/mch_irq_stat.sv
module mch_irq_stat #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set,
  input  logic [NCH-1:0] clr,
  input  logic [NCH-1:0] en,
  output logic [NCH-1:0] sts,
  output logic           irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr) | set;
  end

  assign irq = |(sts & en);
endmodule

// File: rtl/mch_crc_ctl.sv
module mch_crc_ctl #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic           wr_corrupt,
  input  logic           wr_oneshot,
  input  logic [NCH-1:0] wr_en,
  input  logic           sf_end,
  output logic           corrupt,
  output logic           oneshot,
  output logic [NCH-1:0] irq_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corrupt <= 1'b0;
      oneshot <= 1'b0;
      irq_en  <= '0;
    end else if (wr) begin
      corrupt <= wr_corrupt;
      oneshot <= wr_oneshot;
      irq_en  <= wr_en;
    end else if (sf_end && oneshot) begin
      corrupt <= 1'b0;
    end
  end
endmodule

// File: rtl/mch_sframe_ctrl.sv
module mch_sframe_ctrl
  import mch_pkg::*;
#(
  parameter int DW  = 12,
  parameter int QPF = 120,
  parameter int FPS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          quat_stb,
  input  logic          sf_start,
  input  logic [DW-1:0] rx_m4_in,
  input  logic [DW-1:0] rx_m56_in,
  input  logic [DW-1:0] rx_eoc_in,
  input  logic          host_wr,
  input  logic [2:0]    host_wsel,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  input  logic [2:0]    host_rsel,
  output logic [DW-1:0] host_rdata,
  output logic [DW-1:0] tx_m4_out,
  output logic [DW-1:0] tx_m56_out,
  output logic [DW-1:0] tx_eoc_out,
  output logic          crc_bad,
  output logic          irq,
  output logic [6:0]    quat_idx,
  output logic [2:0]    frame_idx
);
  localparam int QW = $clog2(QPF);
  localparam int FW = $clog2(FPS);

  logic                    ev_mid;
  logic                    ev_sf_end;
  logic [NCH-1:0]          ch_load;
  logic [NCH-1:0][DW-1:0]  rx_in;
  logic [NCH-1:0][DW-1:0]  rx_q;
  logic [NCH-1:0][DW-1:0]  hold_q;
  logic [NCH-1:0][DW-1:0]  tx_q;
  logic [NCH-1:0]          rd_clr;
  logic [NCH-1:0]          sts;
  logic [NCH-1:0]          irq_en;
  logic                    oneshot;
  logic                    ctrl_wr;
  logic [QW-1:0]           q_pos;
  logic [FW-1:0]           f_pos;

  mch_sf_pos #(.QPF(QPF), .FPS(FPS), .QW(QW), .FW(FW)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .quat_stb  (quat_stb),
    .sf_start  (sf_start),
    .quat_idx  (q_pos),
    .frame_idx (f_pos),
    .ev_mid    (ev_mid),
    .ev_sf_end (ev_sf_end)
  );

  assign quat_idx  = 7'(q_pos);
  assign frame_idx = 3'(f_pos);

  assign ch_load[CH_M4]  = ev_sf_end;
  assign ch_load[CH_M56] = ev_mid;
  assign ch_load[CH_EOC] = ev_mid || ev_sf_end;

  assign rx_in[CH_M4]  = rx_m4_in;
  assign rx_in[CH_M56] = rx_m56_in;
  assign rx_in[CH_EOC] = rx_eoc_in;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mch_chan_buf #(.DW(DW)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ch_load[c]),
      .rx_in   (rx_in[c]),
      .hold_wr (host_wr && (host_wsel == 3'(c))),
      .hold_d  (host_wdata),
      .rx_q    (rx_q[c]),
      .hold_q  (hold_q[c]),
      .tx_q    (tx_q[c])
    );
    assign rd_clr[c] = host_rd && (host_rsel == 3'(c));
  end

  assign tx_m4_out  = tx_q[CH_M4];
  assign tx_m56_out = tx_q[CH_M56];
  assign tx_eoc_out = tx_q[CH_EOC];

  mch_irq_stat #(.NCH(NCH)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ch_load),
    .clr   (rd_clr),
    .en    (irq_en),
    .sts   (sts),
    .irq   (irq)
  );

  assign ctrl_wr = host_wr && (host_wsel == SEL_CTRL);

  mch_crc_ctl #(.NCH(NCH)) u_crc (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (ctrl_wr),
    .wr_corrupt (host_wdata[CTRL_CORRUPT]),
    .wr_oneshot (host_wdata[CTRL_ONESHOT]),
    .wr_en      (host_wdata[CTRL_EN_LSB +: NCH]),
    .sf_end     (ev_sf_end),
    .corrupt    (crc_bad),
    .oneshot    (oneshot),
    .irq_en     (irq_en)
  );

  always_comb begin
    host_rdata = '0;
    case (host_rsel)
      SEL_M4:   host_rdata = rx_q[CH_M4];
      SEL_M56:  host_rdata = rx_q[CH_M56];
      SEL_EOC:  host_rdata = rx_q[CH_EOC];
      SEL_CTRL: host_rdata = DW'({irq_en, oneshot, crc_bad});
      SEL_STAT: host_rdata = DW'(sts);
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mch_sframe_chk.sv
module mch_sframe_chk #(
  parameter int DW  = 12,
  parameter int QPF = 120,
  parameter int FPS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    quat_idx,
  input logic [2:0]    frame_idx,
  input logic          ev_mid,
  input logic          ev_sf_end,
  input logic [DW-1:0] rx_m4_in,
  input logic [DW-1:0] rx_m56_in,
  input logic [DW-1:0] rx_eoc_in,
  input logic [DW-1:0] rx_m4_q,
  input logic [DW-1:0] rx_m56_q,
  input logic [DW-1:0] rx_eoc_q,
  input logic [DW-1:0] hold_m4,
  input logic [DW-1:0] tx_m4_out,
  input logic [2:0]    sts,
  input logic          oneshot,
  input logic          ctrl_wr,
  input logic          crc_bad,
  input logic          host_rd,
  input logic [2:0]    host_rsel
);
  a_r1_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(quat_idx) < QPF) && (32'(frame_idx) < FPS));

  a_r2_m56_load: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mid |=> rx_m56_q == $past(rx_m56_in));

  a_r3_m4_load: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sf_end |=> rx_m4_q == $past(rx_m4_in));

  a_r4_eoc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mid || ev_sf_end) |=> rx_eoc_q == $past(rx_eoc_in));

  a_r5_tx_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sf_end |=> tx_m4_out == $past(hold_m4));

  a_r5_tx_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_sf_end |=> $stable(tx_m4_out));

  a_r6_mid_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mid |=> sts[2] && sts[1]);

  a_r6_end_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sf_end |=> sts[2] && sts[0]);

  a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_rsel == 3'd0 && !ev_sf_end) |=> !sts[0]);

  a_r9_oneshot_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sf_end && oneshot && !ctrl_wr) |=> !crc_bad);

  a_r10_corrupt_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sf_end && !oneshot && crc_bad && !ctrl_wr) |=> crc_bad);
endmodule

bind mch_sframe_ctrl mch_sframe_chk #(.DW(DW), .QPF(QPF), .FPS(FPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .quat_idx  (quat_idx),
  .frame_idx (frame_idx),
  .ev_mid    (ev_mid),
  .ev_sf_end (ev_sf_end),
  .rx_m4_in  (rx_m4_in),
  .rx_m56_in (rx_m56_in),
  .rx_eoc_in (rx_eoc_in),
  .rx_m4_q   (rx_q[0]),
  .rx_m56_q  (rx_q[1]),
  .rx_eoc_q  (rx_q[2]),
  .hold_m4   (hold_q[0]),
  .tx_m4_out (tx_m4_out),
  .sts       (sts),
  .oneshot   (oneshot),
  .ctrl_wr   (ctrl_wr),
  .crc_bad   (crc_bad),
  .host_rd   (host_rd),
  .host_rsel (host_rsel)
);

// File: tb/mch_sframe_ctrl_test.sv
module mch_sframe_ctrl_test;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          quat_stb = 1'b0, sf_start = 1'b0;
  logic [DW-1:0] rx_m4_in = '0, rx_m56_in = '0, rx_eoc_in = '0;
  logic          host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]    host_wsel = '0, host_rsel = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata, tx_m4_out, tx_m56_out, tx_eoc_out;
  logic          crc_bad, irq;
  logic [6:0]    quat_idx;
  logic [2:0]    frame_idx;

  always #5 clk = ~clk;

  mch_sframe_ctrl #(.DW(DW)) uut (.*);

  int n_chk = 0, n_fail = 0;

  // reference state, built from the requirements
  int            mq = 119, mf = 7;
  logic [DW-1:0] m_rx [3];
  logic [DW-1:0] m_hold [3];
  logic [DW-1:0] m_tx [3];
  logic [2:0]    m_st = '0, m_en = '0;
  logic          m_cor = 1'b0, m_one = 1'b0;
  logic          last_e4 = 1'b0, last_e8 = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [2:0] sel);
    case (sel)
      3'd0, 3'd1, 3'd2: return m_rx[sel];
      3'd3: return DW'({m_en, m_one, m_cor});
      3'd4: return DW'(m_st);
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |(m_st & m_en);
  endfunction

  // one clock: inputs are already set at a falling edge
  task automatic cyc();
    int nq, nf;
    logic e4, e8;
    #1;
    chk("R6/R7/R9 read data", 32'(host_rdata), 32'(exp_read(host_rsel)));
    nq = mq; nf = mf; e4 = 1'b0; e8 = 1'b0;
    if (quat_stb) begin
      if (sf_start) begin nq = 0; nf = 0; end
      else if (mq == 119) begin nq = 0; nf = (mf + 1) % 8; end
      else nq = mq + 1;
      e4 = (nq == 119) && (nf == 3);
      e8 = (nq == 119) && (nf == 7);
    end
    @(posedge clk);
    mq = nq; mf = nf; last_e4 = e4; last_e8 = e8;
    if (e8) begin m_tx[0] = m_hold[0]; m_rx[0] = rx_m4_in; end
    if (e4) begin m_tx[1] = m_hold[1]; m_rx[1] = rx_m56_in; end
    if (e4 || e8) begin m_tx[2] = m_hold[2]; m_rx[2] = rx_eoc_in; end
    if (host_wr && host_wsel < 3) m_hold[host_wsel] = host_wdata;
    if (host_rd && host_rsel < 3) m_st[host_rsel] = 1'b0;
    if (e8) begin m_st[0] = 1'b1; m_st[2] = 1'b1; end
    if (e4) begin m_st[1] = 1'b1; m_st[2] = 1'b1; end
    if (host_wr && host_wsel == 3) begin
      m_cor = host_wdata[0]; m_one = host_wdata[1]; m_en = host_wdata[4:2];
    end else if (e8 && m_one) m_cor = 1'b0;
    @(negedge clk);
    chk("R1 quat index", 32'(quat_idx), 32'(mq));
    chk("R1 frame index", 32'(frame_idx), 32'(mf));
    chk("R5 tx M4", 32'(tx_m4_out), 32'(m_tx[0]));
    chk("R5 tx M5/M6", 32'(tx_m56_out), 32'(m_tx[1]));
    chk("R5 tx eoc", 32'(tx_eoc_out), 32'(m_tx[2]));
    chk("R8 irq", 32'(irq), 32'(exp_irq()));
    chk("R9/R10 crc_bad", 32'(crc_bad), 32'(m_cor));
    quat_stb = 1'b0; sf_start = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] sel, output logic [DW-1:0] val);
    host_rsel = sel;
    #1;
    val = host_rdata;
  endtask

  task automatic boundary_checks();
    logic [DW-1:0] v;
    if (last_e4) begin
      peek(3'd1, v); chk("R2 M5/M6 receive at mid point", 32'(v), 32'(m_rx[1]));
      peek(3'd2, v); chk("R4 eoc receive at mid point", 32'(v), 32'(m_rx[2]));
      peek(3'd4, v); chk("R6 status after mid point", 32'(v), 32'(m_st));
    end
    if (last_e8) begin
      peek(3'd0, v); chk("R3 M4 receive at superframe end", 32'(v), 32'(m_rx[0]));
      peek(3'd2, v); chk("R4 eoc receive at superframe end", 32'(v), 32'(m_rx[2]));
      peek(3'd4, v); chk("R6 status after superframe end", 32'(v), 32'(m_st));
    end
  endtask

  task automatic strobe(input logic sf);
    quat_stb = 1'b1; sf_start = sf;
    rx_m4_in = DW'($urandom); rx_m56_in = DW'($urandom); rx_eoc_in = DW'($urandom);
    cyc();
    boundary_checks();
  endtask

  // strobe until the reference position is (q, f)
  task automatic adv_to(input int q, input int f);
    while (!(mq == q && mf == f)) strobe(1'b0);
  endtask

  task automatic rand_cycle();
    int r;
    r = int'($urandom % 16);
    if (r == 0) begin
      host_wr = 1'b1; host_wsel = 3'($urandom % 3); host_wdata = DW'($urandom);
    end else if (r == 1) begin
      host_wr = 1'b1; host_wsel = 3'd3; host_wdata = DW'($urandom & 32'h1f);
    end else if (r == 2 || r == 3) begin
      host_rd = 1'b1; host_rsel = 3'($urandom % 5);
    end else begin
      host_rsel = 3'($urandom % 5);
    end
    if (($urandom % 4) != 0) begin
      quat_stb = 1'b1;
      rx_m4_in = DW'($urandom); rx_m56_in = DW'($urandom); rx_eoc_in = DW'($urandom);
      sf_start = (mq == 119 && mf == 7);
    end
    cyc();
    boundary_checks();
  endtask

  task automatic wr_ctrl(input logic cor, input logic one, input logic [2:0] en);
    host_wr = 1'b1; host_wsel = 3'd3; host_wdata = DW'({en, one, cor});
    cyc();
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v, old_hold, new_hold;
    void'($urandom(32'd7215));
    for (int i = 0; i < 3; i++) begin m_rx[i] = '0; m_hold[i] = '0; m_tx[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1 reset quat index", 32'(quat_idx), 32'd119);
    chk("R1 reset frame index", 32'(frame_idx), 32'd7);
    chk("R8 reset irq", 32'(irq), 32'd0);
    chk("R9 reset crc_bad", 32'(crc_bad), 32'd0);
    peek(3'd4, v); chk("R6 reset status", 32'(v), 32'd0);

    // start marker without strobe is ignored (R1)
    sf_start = 1'b1; host_rsel = 3'd0; cyc();
    chk("R1 marker without strobe", 32'(quat_idx), 32'd119);

    // random traffic over several superframes
    wr_ctrl(1'b0, 1'b0, 3'b111);
    for (int n = 0; n < 5200; n++) rand_cycle();

    // mid-frame resync with the start marker (R1)
    adv_to(40, 2);
    strobe(1'b1);
    chk("R1 resync quat", 32'(quat_idx), 32'd0);
    chk("R1 resync frame", 32'(frame_idx), 32'd0);

    // one-shot corrupt clears after exactly one superframe (R9)
    wr_ctrl(1'b1, 1'b1, 3'b001);
    adv_to(118, 7);
    chk("R9 corrupt held before superframe end", 32'(crc_bad), 32'd1);
    strobe(1'b0);
    chk("R9 one-shot cleared at superframe end", 32'(crc_bad), 32'd0);
    strobe(1'b1);
    adv_to(118, 7);
    strobe(1'b0);
    chk("R9 stays clear until set again", 32'(crc_bad), 32'd0);

    // control write wins on the superframe-end cycle (R9)
    wr_ctrl(1'b1, 1'b1, 3'b001);
    strobe(1'b1);
    adv_to(118, 7);
    quat_stb = 1'b1; host_wr = 1'b1; host_wsel = 3'd3; host_wdata = DW'(5'b00111);
    cyc();
    chk("R9 write wins over self-clear", 32'(crc_bad), 32'd1);

    // non-one-shot keeps corrupt across superframe ends (R10)
    wr_ctrl(1'b1, 1'b0, 3'b111);
    for (int s = 0; s < 2; s++) begin
      strobe(1'b1);
      adv_to(119, 7);
      chk("R10 corrupt kept after superframe end", 32'(crc_bad), 32'd1);
    end
    wr_ctrl(1'b0, 1'b0, 3'b111);

    // holding write on the copy cycle reaches the line one superframe later (R5)
    old_hold = m_hold[0];
    new_hold = ~old_hold;
    strobe(1'b1);
    adv_to(118, 7);
    quat_stb = 1'b1; host_wr = 1'b1; host_wsel = 3'd0; host_wdata = new_hold;
    cyc();
    chk("R5 write on copy cycle not yet sent", 32'(tx_m4_out), 32'(old_hold));
    strobe(1'b1);
    adv_to(118, 7);
    chk("R5 new value still held mid superframe", 32'(tx_m4_out), 32'(old_hold));
    strobe(1'b0);
    chk("R5 new value sent at next copy point", 32'(tx_m4_out), 32'(new_hold));

    // read and set in the same cycle: set wins (R7)
    strobe(1'b1);
    adv_to(118, 7);
    quat_stb = 1'b1; host_rd = 1'b1; host_rsel = 3'd0;
    cyc();
    peek(3'd4, v); chk("R7 set wins over read clear", 32'(v[0]), 32'd1);
    host_rd = 1'b1; host_rsel = 3'd0; cyc();
    peek(3'd4, v); chk("R7 read clears M4 status", 32'(v[0]), 32'd0);
    chk("R6 eoc status untouched by M4 read", 32'(v[2]), 32'd1);
    host_rsel = 3'd2; cyc();
    peek(3'd4, v); chk("R7 no clear without read strobe", 32'(v[2]), 32'd1);

    // mid point sets eoc and M5/M6 but not M4 (R6)
    host_rd = 1'b1; host_rsel = 3'd2; cyc();
    host_rd = 1'b1; host_rsel = 3'd1; cyc();
    strobe(1'b1);
    adv_to(119, 3);
    peek(3'd4, v); chk("R6 mid point status bits", 32'(v[2:0]), 32'b110);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule